// File: doc/BRIEF.md
# Peripheral FIFO Write Strobe Sequencer

This block is the master side of an asynchronous strobe link to an external peripheral FIFO. It turns byte requests from a valid/ready port into strobe cycles on the peripheral's pins: address lines, a chip select, a write strobe and an 8-bit data bus. A second valid/ready port asks for a packet-end pulse, which tells the peripheral to close a short packet. Every setup, pulse-width and hold interval is a whole number of system-clock cycles, set by a parameter.

The peripheral latches the byte when the write strobe goes inactive and then moves its own FIFO pointer on. A burst is therefore a run of strobe cycles with the address unchanged. When the address matches the one already on the pins, the address setup phase is skipped. After each strobe the block waits out the peripheral's flag delay. Only then does it use the registered full flag to decide whether to take the next byte. A byte that meets a full FIFO is stalled, not dropped. The active level of the chip select, the two strobes and the full flag is chosen by parameters.

Top module: `fifo_wr_seq`

## Requirements
- R1: After reset the chip select, write strobe and packet-end strobe are at their inactive levels, the address bus is 0, and both ready outputs are high while no commit is requested.
- R2: Before a strobe that uses a new address, or before the first strobe after reset, the address is driven with chip select active for T_ADDR_SU cycles with both strobes inactive. When the address equals the one already driven, the strobe starts in the cycle right after acceptance.
- R3: The write strobe is active for exactly max(T_WR_ON, T_DATA_SU) cycles. The accepted byte is on the data bus from the first of those cycles and does not change while the strobe is active.
- R4: After the write strobe goes inactive, the data, the address and chip select stay unchanged for max(T_WR_OFF, T_DATA_HOLD, T_ADDR_HOLD) cycles and then for T_FLAG_DLY more cycles. Only after that does the block return to idle.
- R5: In idle, wr_ready is high only when the full flag registered one clock earlier is inactive and no commit is requested. A stalled byte stays pending and is written once the flag clears.
- R6: cm_ready is high exactly in idle cycles. When both requests are pending in idle, the commit is accepted first. A commit raised during a strobe cycle waits until that cycle is complete.
- R7: The packet-end strobe is active for T_END_ON cycles. After it, the address is held and both strobes stay inactive for max(T_END_OFF, T_ADDR_HOLD) cycles. The packet-end strobe is never active in the same cycle as the write strobe, nor in the cycle right after it.
- R8: Chip select is active in every non-idle cycle, including every cycle with a strobe active. It is inactive in idle cycles.
- R9: With a polarity parameter set to 1 the corresponding signal (CS_ACT_LOW, WR_ACT_LOW, PE_ACT_LOW, FULL_ACT_LOW) is active low; with 0 it is active high.
- R10: The peripheral sees the accepted bytes in acceptance order. At each inactive-going edge of the write strobe, the address and data on the pins are those of the request being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Byte request accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | FIFO address for the byte |
| wr_data | input | DATA_W | Byte to write |
| cm_valid | input | 1 | Packet-end (commit) request |
| cm_ready | output | 1 | Commit accepted this cycle when high with cm_valid |
| cm_addr | input | ADDR_W | FIFO address to commit |
| fifo_addr | output | ADDR_W | Peripheral FIFO address lines |
| fifo_cs | output | 1 | Peripheral chip select, polarity by CS_ACT_LOW |
| fifo_wr | output | 1 | Write strobe, polarity by WR_ACT_LOW |
| fifo_pe | output | 1 | Packet-end strobe, polarity by PE_ACT_LOW |
| fifo_data | output | DATA_W | Peripheral data bus |
| fifo_full | input | 1 | Peripheral full flag, polarity by FULL_ACT_LOW |

## Verification
The patterns are a single write to a fresh address, a back-to-back burst to the same address, and a commit to the current address and to a new one. These show whether the address setup phase is entered or skipped. One run holds the full flag active while a byte waits; this shows stalling apart from dropping, and checks that writing resumes once the flag clears. Another raises a commit and a byte together while a strobe cycle is in progress; this shows whether the commit waits for the cycle to finish and is then given priority. The pin levels are predicted cycle by cycle from the interval parameters. Every byte latched at a strobe's trailing edge is matched against the acceptance order.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_STROBE_ON,
        ST_STROBE_OFF,
        ST_FLAG_WAIT,
        ST_END_ON,
        ST_END_OFF
    } state_t;

    typedef struct packed {
        logic cs;
        logic wr;
        logic pe;
    } strobe_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_of(input state_t s);
        strobe_t r;
        r.cs = (s != ST_IDLE);
        r.wr = (s == ST_STROBE_ON);
        r.pe = (s == ST_END_ON);
        return r;
    endfunction

endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] value,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fws_pol.sv
module fws_pol #(
    parameter int           N   = 1,
    parameter logic [N-1:0] INV = '0
) (
    input  logic [N-1:0] a,
    output logic [N-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (INV[i]) begin : g_inv
            assign y[i] = ~a[i];
        end else begin : g_pass
            assign y[i] = a[i];
        end
    end
endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
    import fws_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int T_ADDR_SU   = 2,
    parameter int T_WR_ON     = 3,
    parameter int T_WR_OFF    = 2,
    parameter int T_DATA_SU   = 4,
    parameter int T_DATA_HOLD = 1,
    parameter int T_FLAG_DLY  = 3,
    parameter int T_END_ON    = 2,
    parameter int T_END_OFF   = 3,
    parameter int T_ADDR_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cm_valid,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic              full_act,
    output logic              wr_ready,
    output logic              cm_ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output strobe_t           act
);
    localparam int ON_LEN   = imax(T_WR_ON, T_DATA_SU);
    localparam int OFF_LEN  = imax(imax(T_WR_OFF, T_DATA_HOLD), T_ADDR_HOLD);
    localparam int EOFF_LEN = imax(T_END_OFF, T_ADDR_HOLD);
    localparam int LONGEST  = imax(imax(imax(T_ADDR_SU, ON_LEN), imax(OFF_LEN, T_FLAG_DLY)),
                                   imax(T_END_ON, EOFF_LEN));
    localparam int CW       = $clog2(LONGEST + 1);

    state_t      st, nxt;
    logic        addr_ok, op_end, full_seen;
    logic        zero, load;
    logic [CW-1:0] lval;
    logic        take_wr, take_cm, go_setup;

    function automatic logic [CW-1:0] span(input state_t s);
        case (s)
            ST_ADDR_SETUP: return CW'(T_ADDR_SU - 1);
            ST_STROBE_ON:  return CW'(ON_LEN - 1);
            ST_STROBE_OFF: return CW'(OFF_LEN - 1);
            ST_FLAG_WAIT:  return CW'(T_FLAG_DLY - 1);
            ST_END_ON:     return CW'(T_END_ON - 1);
            ST_END_OFF:    return CW'(EOFF_LEN - 1);
            default:       return '0;
        endcase
    endfunction

    assign cm_ready = (st == ST_IDLE);
    assign wr_ready = (st == ST_IDLE) && !full_seen && !cm_valid;
    assign take_cm  = cm_ready && cm_valid;
    assign take_wr  = wr_ready && wr_valid;
    assign go_setup = !addr_ok || ((take_cm ? cm_addr : wr_addr) != addr_q);

    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE: begin
                if (take_cm)
                    nxt = go_setup ? ST_ADDR_SETUP : ST_END_ON;
                else if (take_wr)
                    nxt = go_setup ? ST_ADDR_SETUP : ST_STROBE_ON;
            end
            ST_ADDR_SETUP: if (zero) nxt = op_end ? ST_END_ON : ST_STROBE_ON;
            ST_STROBE_ON:  if (zero) nxt = ST_STROBE_OFF;
            ST_STROBE_OFF: if (zero) nxt = ST_FLAG_WAIT;
            ST_FLAG_WAIT:  if (zero) nxt = ST_IDLE;
            ST_END_ON:     if (zero) nxt = ST_END_OFF;
            ST_END_OFF:    if (zero) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
        load = (nxt != st) && (nxt != ST_IDLE);
        lval = span(nxt);
    end

    fws_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .value (lval),
        .zero  (zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            addr_q    <= '0;
            data_q    <= '0;
            addr_ok   <= 1'b0;
            op_end    <= 1'b0;
            full_seen <= 1'b0;
        end else begin
            st        <= nxt;
            full_seen <= full_act;
            if (take_cm) begin
                addr_q  <= cm_addr;
                addr_ok <= 1'b1;
                op_end  <= 1'b1;
            end else if (take_wr) begin
                addr_q  <= wr_addr;
                data_q  <= wr_data;
                addr_ok <= 1'b1;
                op_end  <= 1'b0;
            end
        end
    end

    assign act = strobes_of(st);
endmodule

// File: rtl/fifo_wr_seq.sv
module fifo_wr_seq
    import fws_pkg::*;
#(
    parameter int ADDR_W       = 2,
    parameter int DATA_W       = 8,
    parameter int T_ADDR_SU    = 2,
    parameter int T_WR_ON      = 3,
    parameter int T_WR_OFF     = 2,
    parameter int T_DATA_SU    = 4,
    parameter int T_DATA_HOLD  = 1,
    parameter int T_FLAG_DLY   = 3,
    parameter int T_END_ON     = 2,
    parameter int T_END_OFF    = 3,
    parameter int T_ADDR_HOLD  = 2,
    parameter bit CS_ACT_LOW   = 1'b1,
    parameter bit WR_ACT_LOW   = 1'b1,
    parameter bit PE_ACT_LOW   = 1'b1,
    parameter bit FULL_ACT_LOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cm_valid,
    output logic              cm_ready,
    input  logic [ADDR_W-1:0] cm_addr,
    output logic [ADDR_W-1:0] fifo_addr,
    output logic              fifo_cs,
    output logic              fifo_wr,
    output logic              fifo_pe,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_full
);
    strobe_t    act;
    logic [2:0] pins;
    logic [0:0] full_act;

    fws_pol #(.N(1), .INV(FULL_ACT_LOW)) full_pol_i (
        .a (fifo_full),
        .y (full_act)
    );

    fws_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ADDR_SU(T_ADDR_SU),
        .T_WR_ON(T_WR_ON), .T_WR_OFF(T_WR_OFF), .T_DATA_SU(T_DATA_SU),
        .T_DATA_HOLD(T_DATA_HOLD), .T_FLAG_DLY(T_FLAG_DLY), .T_END_ON(T_END_ON),
        .T_END_OFF(T_END_OFF), .T_ADDR_HOLD(T_ADDR_HOLD)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cm_valid (cm_valid),
        .cm_addr  (cm_addr),
        .full_act (full_act[0]),
        .wr_ready (wr_ready),
        .cm_ready (cm_ready),
        .addr_q   (fifo_addr),
        .data_q   (fifo_data),
        .act      (act)
    );

    fws_pol #(.N(3), .INV({CS_ACT_LOW, WR_ACT_LOW, PE_ACT_LOW})) out_pol_i (
        .a ({act.cs, act.wr, act.pe}),
        .y (pins)
    );

    assign fifo_cs = pins[2];
    assign fifo_wr = pins[1];
    assign fifo_pe = pins[0];
endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter bit CS_ACT_LOW = 1'b1,
    parameter bit WR_ACT_LOW = 1'b1,
    parameter bit PE_ACT_LOW = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fifo_addr,
    input logic [DATA_W-1:0] fifo_data,
    input logic              fifo_cs,
    input logic              fifo_wr,
    input logic              fifo_pe
);
    logic cs_a, wr_a, pe_a;
    assign cs_a = fifo_cs ^ CS_ACT_LOW;
    assign wr_a = fifo_wr ^ WR_ACT_LOW;
    assign pe_a = fifo_pe ^ PE_ACT_LOW;

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(wr_a && pe_a));
    // R7
    end_gap_chk: assert property (@(posedge clk) disable iff (rst) $rose(pe_a) |-> !$past(wr_a));
    // R7
    end_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_a && $past(pe_a)) |-> $stable(fifo_addr));
    // R8
    cs_cover_chk: assert property (@(posedge clk) disable iff (rst) (wr_a || pe_a) |-> cs_a);
    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (rst) $rose(wr_a) |-> $stable(fifo_addr));
    // R3
    data_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a && $past(wr_a)) |-> $stable(fifo_data));
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_a) |-> ($stable(fifo_data) && $stable(fifo_addr)));
endmodule

bind fifo_wr_seq fws_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_ACT_LOW(CS_ACT_LOW),
    .WR_ACT_LOW(WR_ACT_LOW), .PE_ACT_LOW(PE_ACT_LOW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .fifo_addr (fifo_addr),
    .fifo_data (fifo_data),
    .fifo_cs   (fifo_cs),
    .fifo_wr   (fifo_wr),
    .fifo_pe   (fifo_pe)
);

// File: tb/fifo_wr_seq_tb_top.sv
module fifo_wr_seq_tb_top;
    localparam int TSU = 2, TWON = 3, TWOFF = 2, TDSU = 4, TDH = 1;
    localparam int TFLG = 3, TEON = 2, TEOFF = 3, TAH = 2;
    localparam bit CSL = 1'b1, WRL = 1'b1, PEL = 1'b1, FLL = 1'b1;
    localparam int ON_N   = (TWON > TDSU) ? TWON : TDSU;
    localparam int OFF_N0 = (TWOFF > TDH) ? TWOFF : TDH;
    localparam int OFF_N  = (OFF_N0 > TAH) ? OFF_N0 : TAH;
    localparam int EOFF_N = (TEOFF > TAH) ? TEOFF : TAH;

    typedef struct {
        bit cs, wr, pe;
        logic [1:0] addr;
        logic [7:0] data;
        bit dchk;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0, cm_valid = 1'b0;
    logic [1:0] wr_addr = '0, cm_addr = '0;
    logic [7:0] wr_data = '0;
    logic fifo_full;
    logic wr_ready, cm_ready, fifo_cs, fifo_wr, fifo_pe;
    logic [1:0] fifo_addr;
    logic [7:0] fifo_data;
    bit   full_drv = 1'b0;

    int tests = 0, fails = 0;
    exp_t exq[$];
    logic [9:0] wlog[$];
    bit   cur_idle = 1'b1, full_lat = 1'b0, addr_ok = 1'b0, prev_wr = 1'b0;
    logic [1:0] cur_addr = '0;

    always #5 clk = ~clk;
    assign fifo_full = full_drv ^ FLL;

    fifo_wr_seq #(
        .ADDR_W(2), .DATA_W(8), .T_ADDR_SU(TSU), .T_WR_ON(TWON), .T_WR_OFF(TWOFF),
        .T_DATA_SU(TDSU), .T_DATA_HOLD(TDH), .T_FLAG_DLY(TFLG), .T_END_ON(TEON),
        .T_END_OFF(TEOFF), .T_ADDR_HOLD(TAH), .CS_ACT_LOW(CSL), .WR_ACT_LOW(WRL),
        .PE_ACT_LOW(PEL), .FULL_ACT_LOW(FLL)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .cm_valid(cm_valid), .cm_ready(cm_ready),
        .cm_addr(cm_addr), .fifo_addr(fifo_addr), .fifo_cs(fifo_cs), .fifo_wr(fifo_wr),
        .fifo_pe(fifo_pe), .fifo_data(fifo_data), .fifo_full(fifo_full)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input bit cs, input bit wr, input bit pe, input logic [1:0] a,
                        input logic [7:0] d, input bit dc, input string tag, input int n);
        exp_t e;
        e.cs = cs; e.wr = wr; e.pe = pe; e.addr = a; e.data = d; e.dchk = dc; e.tag = tag;
        for (int i = 0; i < n; i++) exq.push_back(e);
    endtask

    task automatic plan_setup(input logic [1:0] a);
        if (!addr_ok || a != cur_addr) push(1, 0, 0, a, 8'h00, 0, "R2 setup", TSU);
        addr_ok = 1'b1;
        cur_addr = a;
    endtask

    task automatic plan_write(input logic [1:0] a, input logic [7:0] d);
        plan_setup(a);
        push(1, 1, 0, a, d, 1, "R3 strobe", ON_N);
        push(1, 0, 0, a, d, 1, "R4 hold", OFF_N);
        push(1, 0, 0, a, d, 1, "R4 flag wait", TFLG);
        wlog.push_back({a, d});
    endtask

    task automatic plan_commit(input logic [1:0] a);
        plan_setup(a);
        push(1, 0, 1, a, 8'h00, 0, "R7 end pulse", TEON);
        push(1, 0, 0, a, 8'h00, 0, "R7 end gap", EOFF_N);
    endtask

    task automatic step();
        bit er, ec, wacc, cacc;
        exp_t e;
        bit wr_now;
        #1;
        ec = cur_idle;
        er = cur_idle && !full_lat && !cm_valid;
        chk(wr_ready === er, "R5 wr_ready", wr_ready, er);
        chk(cm_ready === ec, "R6 cm_ready", cm_ready, ec);
        cacc = cm_valid && ec;
        wacc = wr_valid && er;
        if (cacc) plan_commit(cm_addr);
        else if (wacc) plan_write(wr_addr, wr_data);
        @(posedge clk);
        full_lat = full_drv;
        @(negedge clk);
        if (cacc) cm_valid = 1'b0;
        if (wacc) wr_valid = 1'b0;
        cur_idle = (exq.size() == 0);
        if (cur_idle) begin
            e.cs = 0; e.wr = 0; e.pe = 0; e.addr = cur_addr; e.data = 0; e.dchk = 0; e.tag = "R8 idle";
        end else e = exq.pop_front();
        chk(fifo_cs === (e.cs ^ CSL), {e.tag, " cs"}, fifo_cs, e.cs ^ CSL);
        chk(fifo_wr === (e.wr ^ WRL), {e.tag, " wr"}, fifo_wr, e.wr ^ WRL);
        chk(fifo_pe === (e.pe ^ PEL), {e.tag, " pe"}, fifo_pe, e.pe ^ PEL);
        chk(fifo_addr === e.addr, {e.tag, " addr"}, fifo_addr, e.addr);
        if (e.dchk) chk(fifo_data === e.data, {e.tag, " data"}, fifo_data, e.data);
        wr_now = fifo_wr ^ WRL;
        if (prev_wr && !wr_now) begin
            if (wlog.size() == 0) chk(0, "R10 unexpected byte", {fifo_addr, fifo_data}, 0);
            else begin
                logic [9:0] w;
                w = wlog.pop_front();
                chk({fifo_addr, fifo_data} === w, "R10 latched byte", {fifo_addr, fifo_data}, w);
            end
        end
        prev_wr = wr_now;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (exq.size() != 0 || !cur_idle || wr_valid || cm_valid); i++) step();
        step();
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        for (int i = 0; i < 200 && wr_valid; i++) step();
    endtask

    task automatic do_commit(input logic [1:0] a);
        cm_addr = a; cm_valid = 1'b1;
        for (int i = 0; i < 200 && cm_valid; i++) step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state, R9 raw levels are active-low inactive (high)
        chk(fifo_cs === 1'b1 && fifo_wr === 1'b1 && fifo_pe === 1'b1, "R1 R9 strobes idle",
            {fifo_cs, fifo_wr, fifo_pe}, 3'b111);
        chk(fifo_addr === 2'd0, "R1 addr", fifo_addr, 0);
        chk(wr_ready === 1'b1 && cm_ready === 1'b1, "R1 readies", {wr_ready, cm_ready}, 2'b11);
        @(negedge clk);

        do_write(2'd1, 8'hA5);          // single, with setup (R2)
        drain();
        do_write(2'd1, 8'h11);          // burst, setup skipped (R2)
        do_write(2'd1, 8'h22);
        do_write(2'd1, 8'h33);
        drain();
        do_commit(2'd1);                // commit at current address (R7)
        drain();
        do_write(2'd2, 8'h77);          // new address (R2)
        drain();

        full_drv = 1'b1;                // R5 stall while full
        step(); step();
        wr_addr = 2'd2; wr_data = 8'h44; wr_valid = 1'b1;
        for (int i = 0; i < 12; i++) step();
        chk(wr_valid === 1'b1, "R5 byte still pending", wr_valid, 1);
        full_drv = 1'b0;
        drain();

        do_write(2'd3, 8'h55);          // R6 commit raised mid-cycle
        step(); step(); step();
        cm_addr = 2'd0; cm_valid = 1'b1;
        wr_addr = 2'd3; wr_data = 8'h66; wr_valid = 1'b1;
        drain();

        do_write(2'd0, 8'h99);          // commit at same address after write
        do_commit(2'd0);
        drain();
        chk(wlog.size() == 0, "R10 all bytes latched", wlog.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule